// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block is a first-level data translation buffer. It maps a 48-bit virtual address to a 36-bit physical address. Three entry arrays are probed at the same time, one for each page size: 4 KiB, 2 MiB and 1 GiB. Each array is set associative. It takes its set index from the virtual page number bits just above its own page offset. The arrays' results merge into one registered answer, one clock after the request: a hit flag, a physical address and a page-size code.

Translations are installed through a fill stream. The page-size code of the fill selects the target array. Inside the indexed set the fill takes an empty way if there is one. If the set is full, a tree pseudo-LRU picks the victim. A flush pin clears every entry in all arrays.

Both request streams use valid/ready. The lookup stream never pushes back: `lk_ready_o` is always high, and a request is taken whenever `lk_valid_i` is high. The result stream has no ready. The sink must take each result in the cycle that `rs_valid_o` is high. The fill stream is refused (`fill_ready_o` low) in any cycle where `flush_i` is high. A fill offered in that cycle is not taken and must be held until it is accepted.

Top module: `tlb_multisize`

## Requirements
- R1: Every accepted lookup produces `rs_valid_o` high exactly one clock later. A cycle without a lookup produces `rs_valid_o` low one clock later. `lk_ready_o` is always high.
- R2: A hit on a 4 KiB page (size code 0) returns {frame[23:0], vaddr[11:0]}.
- R3: A hit on a 2 MiB page (size code 1) returns {frame[14:0], vaddr[20:0]}. Frame bits above bit 14 are ignored.
- R4: A hit on a 1 GiB page (size code 2) returns {frame[5:0], vaddr[29:0]}. A hit never reports size code 3.
- R5: A miss returns hit 0, physical address 0 and size code 0. The hit and multi-hit flags are low whenever `rs_valid_o` is low.
- R6: A fill with size code 3 is accepted but installs nothing.
- R7: The set index is the virtual address bits just above the page offset: bits 15:12 for 4 KiB (16 sets), bits 23:21 for 2 MiB (8 sets), and a single set for 1 GiB. A fill in one set never evicts an entry from another set.
- R8: A fill uses the lowest-numbered empty way of its set first. In a full set it replaces the tree pseudo-LRU victim. Both a hit and a fill make their way the most recently used.
- R9: A fill whose virtual page is already present in its array overwrites that way in place and evicts nothing.
- R10: When arrays of several sizes hit at once, the largest page size supplies the result, and `rs_multihit_o` is raised together with the hit.
- R11: `flush_i` invalidates every entry. A fill offered in the same cycle is refused (`fill_ready_o` low), and later lookups miss.
- R12: When a fill and a lookup occur in the same cycle, the lookup sees the contents from before the fill.
- R13: After reset, no entry is valid and `rs_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup request ready (always high) |
| lk_vaddr_i | input | 48 | Virtual address to translate |
| fill_valid_i | input | 1 | Fill request valid |
| fill_ready_o | output | 1 | Fill request ready (low during flush) |
| fill_size_i | input | 2 | Fill page size: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB, 3 = none |
| fill_vpn_i | input | 36 | Virtual address bits 47:12 of the page being filled |
| fill_frame_i | input | 24 | Physical frame number, right aligned for the page size |
| rs_valid_o | output | 1 | Result valid |
| rs_hit_o | output | 1 | Result is a hit |
| rs_paddr_o | output | 36 | Translated physical address |
| rs_size_o | output | 2 | Page size code of the hit |
| rs_multihit_o | output | 1 | More than one page-size array hit |

## Verification
The bench builds the block with its default parameters: 6 ways × 16 sets for 4 KiB pages, 4 ways × 8 sets for 2 MiB pages, and one set of 8 ways for 1 GiB pages. The 4 KiB array has six ways, so its replacement tree has eight leaves and the victim walk must steer away from the two missing leaves. Filling one set to capacity, touching a way and filling once more gives a victim that follows only from the tree rules. The 2 MiB array can map the same address as a 4 KiB entry, which makes the multi-hit priority easy to exercise.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  localparam int NUM_SIZES = 3;
  localparam int BASE_OFF  = 12;

  // Page offset width for each size code; the array index bits start here.
  function automatic int pg_offset(int k);
    case (k)
      0:       return 12;
      1:       return 21;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/ptlb_plru.sv
module ptlb_plru #(
  parameter  int WAYS = 6,
  localparam int LV   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TW   = 1 << LV
) (
  input  logic [TW-1:0]   tree_i,
  input  logic [WAYS-1:0] valid_i,
  input  logic            fill_en_i,
  input  logic [LV-1:0]   fill_way_i,
  input  logic            hit_en_i,
  input  logic [LV-1:0]   hit_way_i,
  output logic [TW-1:0]   tree_o,
  output logic [LV-1:0]   victim_o
);
  // Heap layout: node n has children 2n and 2n+1; a set bit points right.
  function automatic logic [TW-1:0] touch(logic [TW-1:0] t, logic [LV-1:0] w);
    logic [2*TW-1:0] e;
    logic [LV:0]     n;
    e = {{TW{1'b0}}, t};
    n = (LV+1)'(1);
    for (int l = LV - 1; l >= 0; l--) begin
      e[n] = ~w[l];
      n    = {n[LV-1:0], w[l]};
    end
    return e[TW-1:0];
  endfunction

  function automatic logic [LV-1:0] walk(logic [TW-1:0] t);
    logic [2*TW-1:0] e;
    logic [LV:0]     n;
    logic [LV-1:0]   base;
    e    = {{TW{1'b0}}, t};
    n    = (LV+1)'(1);
    base = '0;
    for (int l = LV - 1; l >= 0; l--) begin
      if (e[n] && (int'(base) + (1 << l) < WAYS)) begin
        base[l] = 1'b1;
        n       = {n[LV-1:0], 1'b1};
      end else begin
        n       = {n[LV-1:0], 1'b0};
      end
    end
    return base;
  endfunction

  logic [TW-1:0] after_fill;

  always_comb begin
    victim_o = walk(tree_i);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) victim_o = LV'(w);
    end
    after_fill = fill_en_i ? touch(tree_i, fill_way_i) : tree_i;
    tree_o     = hit_en_i ? touch(after_fill, hit_way_i) : after_fill;
  end
endmodule

// File: rtl/ptlb_array.sv
module ptlb_array #(
  parameter  int WAYS  = 6,
  parameter  int SETS  = 16,
  parameter  int OFF_W = 12,
  parameter  int VA_W  = 48,
  parameter  int PA_W  = 36,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int NS    = 1 << IDX_W,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int FR_W  = PA_W - OFF_W,
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TW    = 1 << WW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lk_en_i,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [FR_W-1:0]  fill_fr_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  pa_o
);
  logic [VPN_W-1:0] tag_q [NS][WAYS];
  logic [FR_W-1:0]  frm_q [NS][WAYS];
  logic [WAYS-1:0]  vld_q [NS];
  logic [TW-1:0]    tree_q [NS];
  logic [TW-1:0]    tree_nx [NS];
  logic [WW-1:0]    vic [NS];

  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_set, fl_set;
  logic [WAYS-1:0]  lk_match, fl_match;
  logic             lk_hit;
  logic [WW-1:0]    lk_way, fl_way;

  logic             hit_q;
  logic [FR_W-1:0]  fr_res_q;
  logic [OFF_W-1:0] off_q;

  function automatic logic [IDX_W-1:0] set_of(logic [VPN_W-1:0] vpn);
    return (SETS > 1) ? vpn[IDX_W-1:0] : '0;
  endfunction

  function automatic logic [WW-1:0] lowest(logic [WAYS-1:0] v);
    logic [WW-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (v[w]) r = WW'(w);
    end
    return r;
  endfunction

  always_comb begin
    lk_vpn = lk_va_i[VA_W-1:OFF_W];
    lk_set = set_of(lk_vpn);
    fl_set = set_of(fill_vpn_i);
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_vpn);
      fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fill_vpn_i);
    end
    lk_hit = lk_en_i && (|lk_match);
    lk_way = lowest(lk_match);
    fl_way = (|fl_match) ? lowest(fl_match) : vic[fl_set];
  end

  for (genvar s = 0; s < NS; s++) begin : g_set
    ptlb_plru #(.WAYS(WAYS)) u_plru (
      .tree_i    (tree_q[s]),
      .valid_i   (vld_q[s]),
      .fill_en_i (fill_en_i && (fl_set == IDX_W'(s))),
      .fill_way_i(fl_way),
      .hit_en_i  (lk_hit && (lk_set == IDX_W'(s))),
      .hit_way_i (lk_way),
      .tree_o    (tree_nx[s]),
      .victim_o  (vic[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < NS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NS; s++) tree_q[s] <= tree_nx[s];
      if (fill_en_i) vld_q[fl_set][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fl_set][fl_way] <= fill_vpn_i;
      frm_q[fl_set][fl_way] <= fill_fr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q    <= 1'b0;
      fr_res_q <= '0;
      off_q    <= '0;
    end else begin
      hit_q    <= lk_hit;
      fr_res_q <= frm_q[lk_set][lk_way];
      off_q    <= lk_va_i[OFF_W-1:0];
    end
  end

  assign hit_o = hit_q;
  assign pa_o  = hit_q ? {fr_res_q, off_q} : '0;
endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
  import ptlb_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 36,
  parameter int SM_WAYS = 6,
  parameter int SM_SETS = 16,
  parameter int MD_WAYS = 4,
  parameter int MD_SETS = 8,
  parameter int LG_WAYS = 8,
  parameter int LG_SETS = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     lk_valid_i,
  output logic                     lk_ready_o,
  input  logic [VA_W-1:0]          lk_vaddr_i,
  input  logic                     fill_valid_i,
  output logic                     fill_ready_o,
  input  logic [1:0]               fill_size_i,
  input  logic [VA_W-BASE_OFF-1:0] fill_vpn_i,
  input  logic [PA_W-BASE_OFF-1:0] fill_frame_i,
  output logic                     rs_valid_o,
  output logic                     rs_hit_o,
  output logic [PA_W-1:0]          rs_paddr_o,
  output logic [1:0]               rs_size_o,
  output logic                     rs_multihit_o
);
  logic                 lk_fire, fill_fire, rs_valid_q;
  logic [NUM_SIZES-1:0] hits;
  logic [PA_W-1:0]      pa_k [NUM_SIZES];

  assign lk_ready_o   = 1'b1;
  assign fill_ready_o = ~flush_i;
  assign lk_fire      = lk_valid_i;
  assign fill_fire    = fill_valid_i && !flush_i;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_pg
    localparam int OFF = pg_offset(k);
    localparam int WY  = (k == 0) ? SM_WAYS : (k == 1) ? MD_WAYS : LG_WAYS;
    localparam int ST  = (k == 0) ? SM_SETS : (k == 1) ? MD_SETS : LG_SETS;

    ptlb_array #(
      .WAYS (WY),
      .SETS (ST),
      .OFF_W(OFF),
      .VA_W (VA_W),
      .PA_W (PA_W)
    ) u_arr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .lk_en_i   (lk_fire),
      .lk_va_i   (lk_vaddr_i),
      .fill_en_i (fill_fire && (fill_size_i == 2'(k))),
      .fill_vpn_i(fill_vpn_i[VA_W-BASE_OFF-1:OFF-BASE_OFF]),
      .fill_fr_i (fill_frame_i[PA_W-OFF-1:0]),
      .hit_o     (hits[k]),
      .pa_o      (pa_k[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_valid_q <= 1'b0;
    else         rs_valid_q <= lk_fire;
  end

  // Ascending walk: a larger page size overrides a smaller one.
  always_comb begin
    rs_paddr_o = '0;
    rs_size_o  = PG_4K;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (hits[k]) begin
        rs_paddr_o = pa_k[k];
        rs_size_o  = 2'(k);
      end
    end
  end

  assign rs_valid_o    = rs_valid_q;
  assign rs_hit_o      = rs_valid_q && (|hits);
  assign rs_multihit_o = rs_valid_q && ((hits & (hits - 1'b1)) != '0);
endmodule

// File: rtl/tlb_multisize_chk.sv
module tlb_multisize_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flush_i,
  input logic       lk_valid_i,
  input logic       rs_valid_o,
  input logic       rs_hit_o,
  input logic [1:0] rs_size_o,
  input logic       rs_multihit_o
);
  assert_result_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rs_valid_o);

  assert_no_spurious_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rs_valid_o);

  assert_flags_need_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_valid_o |-> (!rs_hit_o && !rs_multihit_o));

  assert_size_code_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_hit_o |-> (rs_size_o != 2'd3));

  assert_multihit_large_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_multihit_o |-> (rs_hit_o && rs_size_o != 2'd0));

  assert_flush_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 lk_valid_i |=> !rs_hit_o);
endmodule

bind tlb_multisize tlb_multisize_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .lk_valid_i   (lk_valid_i),
  .rs_valid_o   (rs_valid_o),
  .rs_hit_o     (rs_hit_o),
  .rs_size_o    (rs_size_o),
  .rs_multihit_o(rs_multihit_o)
);

// File: tb/test_tlb_multisize.sv
module test_tlb_multisize;
  typedef struct packed {
    logic [1:0]  sz;
    logic [47:0] va;
    logic [23:0] pfn;
    logic [35:0] pa;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{sz: 2'd0, va: 48'h0000_1234_5ABC, pfn: 24'hABCDE1, pa: 36'hABCDE1ABC},
    '{sz: 2'd0, va: 48'h7FFF_FFFF_F123, pfn: 24'h000042, pa: 36'h000042123},
    '{sz: 2'd1, va: 48'h0000_4060_1234, pfn: 24'h001A2B, pa: 36'h345601234},
    '{sz: 2'd2, va: 48'h0123_8765_4321, pfn: 24'h00002D, pa: 36'hB47654321}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [47:0] lk_vaddr = '0;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [1:0]  fill_size = '0;
  logic [35:0] fill_vpn = '0;
  logic [23:0] fill_frame = '0;
  logic        rs_valid, rs_hit, rs_mh;
  logic [35:0] rs_paddr;
  logic [1:0]  rs_size;

  logic        r_valid, r_hit, r_mh;
  logic [35:0] r_pa;
  logic [1:0]  r_size;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  tlb_multisize i_tlb_multisize (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .flush_i      (flush),
    .lk_valid_i   (lk_valid),
    .lk_ready_o   (lk_ready),
    .lk_vaddr_i   (lk_vaddr),
    .fill_valid_i (fill_valid),
    .fill_ready_o (fill_ready),
    .fill_size_i  (fill_size),
    .fill_vpn_i   (fill_vpn),
    .fill_frame_i (fill_frame),
    .rs_valid_o   (rs_valid),
    .rs_hit_o     (rs_hit),
    .rs_paddr_o   (rs_paddr),
    .rs_size_o    (rs_size),
    .rs_multihit_o(rs_mh)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  task automatic do_fill(logic [1:0] sz, logic [47:0] va, logic [23:0] pfn);
    @(negedge clk);
    fill_valid = 1'b1; fill_size = sz; fill_vpn = va[47:12]; fill_frame = pfn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_lookup(logic [47:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    r_valid = rs_valid; r_hit = rs_hit; r_pa = rs_paddr; r_size = rs_size; r_mh = rs_mh;
  endtask

  task automatic fill_and_lookup(logic [47:0] va, logic [23:0] pfn);
    @(negedge clk);
    fill_valid = 1'b1; fill_size = 2'd0; fill_vpn = va[47:12]; fill_frame = pfn;
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    r_valid = rs_valid; r_hit = rs_hit; r_pa = rs_paddr;
  endtask

  function automatic logic [47:0] sva(int t);
    return (48'(t) << 16) | (48'd3 << 12);
  endfunction

  initial begin
    #(200_000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    chk("R13 rs_valid in reset", 64'(rs_valid), 64'd0);
    chk("R1 lk_ready", 64'(lk_ready), 64'd1);
    rst_n = 1'b1;
    do_lookup(VEC[0].va);
    chk("R13 empty after reset hit", 64'(r_hit), 64'd0);
    chk("R5 miss paddr", 64'(r_pa), 64'd0);
    chk("R5 miss size", 64'(r_size), 64'd0);
    @(negedge clk);
    chk("R1 idle gives no result", 64'(rs_valid), 64'd0);

    // Vector table: R2 R3 R4
    for (int i = 0; i < 4; i++) do_fill(VEC[i].sz, VEC[i].va, VEC[i].pfn);
    for (int i = 0; i < 4; i++) begin
      string req;
      req = (VEC[i].sz == 2'd0) ? "R2" : (VEC[i].sz == 2'd1) ? "R3" : "R4";
      do_lookup(VEC[i].va);
      chk("R1 result valid", 64'(r_valid), 64'd1);
      chk({req, " hit"}, 64'(r_hit), 64'd1);
      chk({req, " paddr"}, 64'(r_pa), 64'(VEC[i].pa));
      chk({req, " size"}, 64'(r_size), 64'(VEC[i].sz));
    end

    // R6: size code 3 installs nothing
    do_fill(2'd3, 48'h0000_0AAA_A000, 24'h000001);
    do_lookup(48'h0000_0AAA_A000);
    chk("R6 reserved size ignored", 64'(r_hit), 64'd0);

    // R8: fill set 3 of the 4 KiB array, touch way 0, refill
    for (int t = 1; t <= 6; t++) do_fill(2'd0, sva(t), 24'h100 + 24'(t));
    do_lookup(sva(1));
    chk("R8 first fill hit", 64'(r_hit), 64'd1);
    do_fill(2'd0, sva(7), 24'h000107);
    do_lookup(sva(7));
    chk("R8 new entry paddr", 64'(r_pa), 64'h000107000);
    do_lookup(sva(5));
    chk("R8 plru victim evicted", 64'(r_hit), 64'd0);
    do_lookup(sva(1));
    chk("R8 touched way kept", 64'(r_hit), 64'd1);
    // R7: other sets untouched
    do_lookup(VEC[0].va);
    chk("R7 set 5 kept", 64'(r_hit), 64'd1);
    do_lookup(VEC[1].va);
    chk("R7 set 15 kept", 64'(r_hit), 64'd1);

    // R9: refill a present page in place
    do_fill(2'd0, sva(7), 24'h0001F7);
    do_lookup(sva(7));
    chk("R9 overwritten paddr", 64'(r_pa), 64'h0001F7000);
    for (int t = 1; t <= 6; t++) begin
      if (t != 5) begin
        do_lookup(sva(t));
        chk("R9 no eviction", 64'(r_hit), 64'd1);
      end
    end

    // R10: a 2 MiB page over the 4 KiB entry of VEC[0]
    do_fill(2'd1, VEC[0].va, 24'h000777);
    do_lookup(VEC[0].va);
    chk("R10 paddr from larger page", 64'(r_pa), 64'h0EEF45ABC);
    chk("R10 size", 64'(r_size), 64'd1);
    chk("R10 multihit flag", 64'(r_mh), 64'd1);
    do_lookup(VEC[1].va);
    chk("R10 single hit no flag", 64'(r_mh), 64'd0);

    // R12: same-cycle fill and lookup
    fill_and_lookup(48'h0000_0000_9000, 24'h000999);
    chk("R12 lookup sees old contents", 64'(r_hit), 64'd0);
    do_lookup(48'h0000_0000_9000);
    chk("R12 fill visible next", 64'(r_pa), 64'h000999000);

    // R11: flush with a competing fill
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_size = 2'd0;
    fill_vpn = 36'h00000000B; fill_frame = 24'h000005;
    #1;
    chk("R11 fill refused in flush", 64'(fill_ready), 64'd0);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    do_lookup(VEC[0].va);
    chk("R11 4K/2M flushed", 64'(r_hit), 64'd0);
    do_lookup(VEC[2].va);
    chk("R11 2M flushed", 64'(r_hit), 64'd0);
    do_lookup(VEC[3].va);
    chk("R11 1G flushed", 64'(r_hit), 64'd0);
    do_lookup(48'h0000_0000_B000);
    chk("R11 refused fill absent", 64'(r_hit), 64'd0);

    finish_run();
  end
endmodule